// File: doc/BRIEF.md
# Variable-Step Resonance Frequency Search

This controller finds the drive frequency at which a resonant load draws the most current. It steps a 32-bit direct-synthesis frequency control word upward through a fixed band, from 20 kHz to 40 kHz. The word relates to the output frequency as f_out = word · f_clk / 2^32. The band limits assume a 100 MHz synthesis clock. At each sweep point the controller lets the load settle by dropping a programmable number of current samples. It then takes one sample and compares it with the sample from the previous point. When the absolute change is small, the operating point is far from resonance and the next increment is the coarse step. When the change is large, the resonance is near and the fine step is used.

While it sweeps, the controller keeps the largest current it has seen and the control word that produced it. After the last point of the band it presents that word on its output and raises a lock flag. It holds both until a new start request arrives, for example after the load has been swapped or has drifted out of match. A start request clears the stored peak and runs the sweep again from the bottom of the band.

Top module: `res_sweep_ctrl`

## Requirements
- R1: `fword_o` always lies within the band from 858993 (20 kHz) to 1717986 (40 kHz), both inclusive.
- R2: After reset, `fword_o` is 858993 and `locked_o` is 0, and both stay so until `start_i` is seen.
- R3: After every change of the sweep word, the first `settle_i` valid samples are never used. The point's measurement is a later valid sample.
- R4: On the first point of a sweep there is no earlier sample. That sample sets the stored peak and the previous-sample value, and the next increment is the fine step.
- R5: On later points, the next increment is `step_coarse_i` when |sample − previous sample| < `thresh_i`, and `step_fine_i` otherwise. The sweep word never decreases during a sweep.
- R6: The stored peak and its word are replaced only by a sample strictly greater than the stored peak. On a tie the earlier, lower word is kept.
- R7: If word + step would pass 1717986, the next point is placed at exactly 1717986. That point is measured, and then the sweep ends.
- R8: When the sweep ends, `locked_o` goes to 1 and `fword_o` shows the word of the stored peak. Both are held until a new start request.
- R9: `start_i` has no effect while a sweep is running.
- R10: `start_i` while locked clears the stored peak and restarts the sweep at 858993, with `locked_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start or restart request; acted on only when idle or locked |
| samp_i | input | 12 | Unsigned load-current amplitude sample |
| samp_vld_i | input | 1 | Strobe marking `samp_i` valid for one cycle |
| thresh_i | input | 12 | Current-change threshold that selects the step size |
| step_coarse_i | input | 32 | Word increment used far from resonance |
| step_fine_i | input | 32 | Word increment used near resonance |
| settle_i | input | 8 | Number of valid samples dropped after each word change |
| fword_o | output | 32 | Frequency control word: sweep point while searching, peak word when locked |
| locked_o | output | 1 | High once the sweep has finished and the peak word is presented |

## Verification
A wrong step decision shows on `fword_o` at the very next word change, one sweep point after the faulty comparison. The bench therefore compares each new word with an independently planned sequence as soon as it appears. A settle counter that lets a disturbed sample through is made visible by the bench: it drives a full-scale value during the settle window, and that value skews the next step choice and the stored peak. Errors in the stored peak or its word stay hidden during the sweep. They appear only when `locked_o` rises, as a wrong held word. Flat-topped and band-edge current curves are used so that the tie rule and the top clamp each decide that word.

// File: rtl/rsw_pkg.sv
package rsw_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned SAMP_W   = 12;
    localparam int unsigned SETTLE_W = 8;
    localparam longint unsigned CLK_HZ = 100_000_000;
    localparam longint unsigned BAND_LO_HZ = 20_000;
    localparam longint unsigned BAND_HI_HZ = 40_000;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SAMP_W-1:0] samp_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_SAMPLE,
        ST_COMPARE,
        ST_STEP,
        ST_LOCKED
    } sweep_st_e;

    // Best point seen so far in the current sweep
    typedef struct packed {
        samp_t level;
        word_t word;
    } peak_t;

    // Control word for a frequency, truncated toward zero
    function automatic word_t hz_to_word(input longint unsigned hz,
                                         input longint unsigned clk_hz);
        longint unsigned num;
        num = hz << WORD_W;
        return word_t'(num / clk_hz);
    endfunction

    function automatic samp_t abs_diff(input samp_t a, input samp_t b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    // Add a step and clamp to the upper band word
    function automatic word_t sat_step(input word_t w, input word_t st,
                                       input word_t hi);
        logic [WORD_W:0] sum;
        sum = {1'b0, w} + {1'b0, st};
        if (sum > {1'b0, hi})
            return hi;
        return sum[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/rsw_settle.sv
module rsw_settle #(
    parameter int unsigned CNT_W = rsw_pkg::SETTLE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    assign done = (cnt_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (tick && !done)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rsw_peak.sv
module rsw_peak
    import rsw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  upd,
    input  logic  first,
    input  samp_t level,
    input  word_t word,
    output samp_t best_level,
    output word_t best_word
);
    peak_t best_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            best_q <= '0;
        else if (upd && (first || level > best_q.level))
            best_q <= '{level: level, word: word};
    end

    assign best_level = best_q.level;
    assign best_word  = best_q.word;
endmodule

// File: rtl/rsw_step.sv
module rsw_step
    import rsw_pkg::*;
(
    input  samp_t cur,
    input  samp_t prev,
    input  samp_t thresh,
    input  logic  first,
    input  word_t coarse,
    input  word_t fine,
    output word_t step
);
    logic use_coarse;

    always_comb begin
        use_coarse = !first && (abs_diff(cur, prev) < thresh);
        step       = use_coarse ? coarse : fine;
    end
endmodule

// File: rtl/res_sweep_ctrl.sv
module res_sweep_ctrl
    import rsw_pkg::*;
#(
    parameter word_t F_LO = hz_to_word(BAND_LO_HZ, CLK_HZ),
    parameter word_t F_HI = hz_to_word(BAND_HI_HZ, CLK_HZ)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [SAMP_W-1:0]   samp_i,
    input  logic                samp_vld_i,
    input  logic [SAMP_W-1:0]   thresh_i,
    input  logic [WORD_W-1:0]   step_coarse_i,
    input  logic [WORD_W-1:0]   step_fine_i,
    input  logic [SETTLE_W-1:0] settle_i,
    output logic [WORD_W-1:0]   fword_o,
    output logic                locked_o
);
    sweep_st_e state_q;
    word_t     word_q;
    word_t     step_q;
    word_t     step_w;
    samp_t     cur_q;
    samp_t     prev_q;
    logic      first_q;
    logic      go;
    logic      settle_done;
    samp_t     best_level;
    word_t     best_word;

    // Start is only honoured when no sweep is in progress
    assign go = start_i && (state_q == ST_IDLE || state_q == ST_LOCKED);

    rsw_settle #(.CNT_W(SETTLE_W)) u_settle (
        .clk   (clk),
        .rst   (rst),
        .clr   (go || state_q == ST_STEP),
        .tick  (samp_vld_i && state_q == ST_SETTLE),
        .limit (settle_i),
        .done  (settle_done)
    );

    rsw_step u_step (
        .cur    (cur_q),
        .prev   (prev_q),
        .thresh (thresh_i),
        .first  (first_q),
        .coarse (step_coarse_i),
        .fine   (step_fine_i),
        .step   (step_w)
    );

    rsw_peak u_peak (
        .clk        (clk),
        .rst        (rst),
        .clr        (go),
        .upd        (state_q == ST_COMPARE),
        .first      (first_q),
        .level      (cur_q),
        .word       (word_q),
        .best_level (best_level),
        .best_word  (best_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            word_q  <= F_LO;
            step_q  <= '0;
            cur_q   <= '0;
            prev_q  <= '0;
            first_q <= 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_LOCKED: begin
                    if (start_i) begin
                        state_q <= ST_SETTLE;
                        word_q  <= F_LO;
                        first_q <= 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (settle_done)
                        state_q <= ST_SAMPLE;
                end
                ST_SAMPLE: begin
                    if (samp_vld_i) begin
                        cur_q   <= samp_i;
                        state_q <= ST_COMPARE;
                    end
                end
                ST_COMPARE: begin
                    prev_q  <= cur_q;
                    first_q <= 1'b0;
                    step_q  <= step_w;
                    state_q <= (word_q == F_HI) ? ST_LOCKED : ST_STEP;
                end
                ST_STEP: begin
                    word_q  <= sat_step(word_q, step_q, F_HI);
                    state_q <= ST_SETTLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign locked_o = (state_q == ST_LOCKED);
    assign fword_o  = locked_o ? best_word : word_q;

endmodule

module rsw_check
    import rsw_pkg::*;
#(
    parameter word_t F_LO = hz_to_word(BAND_LO_HZ, CLK_HZ),
    parameter word_t F_HI = hz_to_word(BAND_HI_HZ, CLK_HZ)
) (
    input logic      clk,
    input logic      rst,
    input logic      start_i,
    input word_t     fword_o,
    input logic      locked_o,
    input sweep_st_e state,
    input samp_t     imax
);
    a_r1_word_in_band: assert property (@(posedge clk) disable iff (rst)
        (fword_o >= F_LO && fword_o <= F_HI));

    a_r5_sweep_ascends: assert property (@(posedge clk) disable iff (rst)
        (!locked_o && $past(!locked_o)) |-> (fword_o >= $past(fword_o)));

    a_r6_peak_never_drops: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && state != ST_LOCKED &&
         $past(state) != ST_IDLE && $past(state) != ST_LOCKED)
        |-> (imax >= $past(imax)));

    a_r8_lock_holds: assert property (@(posedge clk) disable iff (rst)
        ($past(locked_o) && !$past(start_i)) |-> (locked_o && $stable(fword_o)));
endmodule

bind res_sweep_ctrl rsw_check #(.F_LO(F_LO), .F_HI(F_HI)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .fword_o  (fword_o),
    .locked_o (locked_o),
    .state    (state_q),
    .imax     (best_level)
);

// File: tb/sim_res_sweep_ctrl.sv
module sim_res_sweep_ctrl;
    localparam int unsigned LO = 858993;
    localparam int unsigned HI = 1717986;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [11:0] samp_i;
    logic        samp_vld_i;
    logic [11:0] thresh_i;
    logic [31:0] step_coarse_i;
    logic [31:0] step_fine_i;
    logic [7:0]  settle_i;
    logic [31:0] fword_o;
    logic        locked_o;

    always #2 clk = ~clk;

    res_sweep_ctrl u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .samp_i(samp_i),
        .samp_vld_i(samp_vld_i), .thresh_i(thresh_i),
        .step_coarse_i(step_coarse_i), .step_fine_i(step_fine_i),
        .settle_i(settle_i), .fword_o(fword_o), .locked_o(locked_o)
    );

    int n_chk = 0;
    int n_err = 0;
    int unsigned exp_q[$];
    int unsigned exp_lock;
    int pk  = 1300000;
    int cap = 4095;

    task automatic chk(input bit ok, input string tag,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Resonant load model: current amplitude against control word
    function automatic int curve(input int unsigned w);
        int d;
        int v;
        d = (w > pk) ? int'(w - pk) : int'(pk - w);
        d = d >>> 10;
        v = 100 + 1560000 / (400 + d * d);
        if (v > cap) v = cap;
        return v;
    endfunction

    // Scoreboard driver: plans every word the sweep must visit and the lock word
    task automatic plan_sweep(input int unsigned coarse, input int unsigned fine,
                              input int thr);
        int unsigned w;
        int unsigned st;
        int unsigned rem;
        int s;
        int prev;
        int imax;
        bit first;
        w = LO; first = 1'b1; prev = 0; imax = 0; rem = LO;
        forever begin
            s = curve(w);
            if (first || s > imax) begin imax = s; rem = w; end
            if (first) st = fine;
            else st = (((s > prev) ? s - prev : prev - s) < thr) ? coarse : fine;
            prev = s;
            first = 1'b0;
            if (w == HI) break;
            w = (w + st > HI) ? HI : w + st;
            exp_q.push_back(w);
        end
        exp_lock = rem;
    endtask

    // Sample source: full-scale disturbance during the settle window (R3)
    initial begin
        int unsigned gl;
        int cnt;
        int ph;
        gl = LO; cnt = 1000; ph = 0;
        samp_vld_i = 1'b0;
        samp_i = '0;
        forever begin
            @(negedge clk);
            samp_vld_i = 1'b0;
            ph++;
            if (ph == 3) begin
                ph = 0;
                if (fword_o != gl) begin gl = fword_o; cnt = 0; end
                samp_i = (cnt < int'(settle_i)) ? 12'hFFF : 12'(curve(fword_o));
                cnt++;
                samp_vld_i = 1'b1;
            end
        end
    end

    // Scoreboard monitor: each new sweep word is popped and compared
    initial begin
        int unsigned last;
        int unsigned e;
        last = LO;
        forever begin
            @(negedge clk);
            if (rst || locked_o) begin
                last = LO;
            end else if (fword_o != last) begin
                last = fword_o;
                chk(fword_o >= LO && fword_o <= HI, "R1 word in band", fword_o, LO);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 R7 unexpected sweep word", fword_o, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(fword_o == e, "R3 R4 R5 R7 sweep word", fword_o, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic finish_run(input string tag);
        while (!locked_o) @(negedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0, "R7 all planned points visited", exp_q.size(), 0);
        chk(locked_o == 1'b1, "R8 lock flag", locked_o, 1);
        chk(fword_o == exp_lock, {"R6 R8 locked word ", tag}, fword_o, exp_lock);
        repeat (30) @(negedge clk);
        chk(fword_o == exp_lock && locked_o, "R8 lock held", fword_o, exp_lock);
    endtask

    initial begin
        int unsigned w0;
        rst = 1'b1; start_i = 1'b0;
        thresh_i = 12'd200; step_coarse_i = 100000; step_fine_i = 20000;
        settle_i = 8'd3;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(fword_o == LO, "R2 reset word", fword_o, LO);
        chk(locked_o == 1'b0, "R2 reset lock", locked_o, 0);
        repeat (10) @(negedge clk);
        chk(fword_o == LO && !locked_o, "R2 idle holds", fword_o, LO);

        // Run 1: peak mid-band, settle disturbance, start pulsed mid-sweep
        pk = 1300000; cap = 4095;
        plan_sweep(100000, 20000, 200);
        pulse_start();
        repeat (60) @(negedge clk);
        w0 = fword_o;
        pulse_start();
        chk(!locked_o && fword_o >= w0 && fword_o != LO, "R9 start ignored in sweep",
            fword_o, w0);
        finish_run("mid-band peak");

        // Run 2: restart from lock, flat-topped curve (tie rule), no settle
        pk = 1650000; cap = 2500;
        thresh_i = 12'd150; step_coarse_i = 90000; step_fine_i = 15000;
        settle_i = 8'd0;
        plan_sweep(90000, 15000, 150);
        pulse_start();
        chk(fword_o == LO && !locked_o, "R10 restart at band bottom", fword_o, LO);
        finish_run("plateau");

        // Run 3: current rising through whole band, peak at clamped top point
        pk = 1800000; cap = 4095;
        thresh_i = 12'd200; step_coarse_i = 120000; step_fine_i = 25000;
        settle_i = 8'd1;
        plan_sweep(120000, 25000, 200);
        pulse_start();
        finish_run("band top");
        chk(fword_o == HI, "R7 clamp to top word", fword_o, HI);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule